// File: doc/BRIEF.md
# Peripheral Security Access Controller

This block sits between a peripheral bus and a set of peripheral register interfaces. It gives each peripheral slot one security bit: either the whole peripheral may be reached only from the secure world, or both worlds may reach it. The block only gates the slave select and forms the response. Address, write data and enable still go from the bus straight to the peripherals. When a normal-world access targets a peripheral reserved for the secure world, the select is never raised and the block answers the bus with an error in the access phase. The peripheral therefore sees nothing.

The same block also forms the security attribute for each bus master that cannot tag its own transactions, such as a DMA engine. Per master slot, a 2-bit mode pins that master's traffic to normal or secure, or passes through the attribute bit the master drives itself. The block's configuration registers form a protected device of their own. Only secure accesses can reach them, and a sticky lock bit freezes every setting until the next reset. Boot code programs the map, sets the lock, and the map then stays fixed for the rest of the run.

Top module: `psac_top`

## Requirements
- R1: After reset, every peripheral is secure-only (config word 0 reads all ones), every master mode is 00 (config word 1 reads 0), the lock reads 0, and every master attribute output is 1 (normal).
- R2: When a normal-world access (pNonSecure=1) selects a peripheral whose security bit is 1, periSel stays all zero in both setup and access phase. pReady and pSlvErr are 1 in the first access-phase cycle, and pRdata is 0.
- R3: A permitted peripheral access (secure, or to a shared peripheral) drives periSel equal to pSel in both phases. pReady follows the selected peripheral's ready, and pRdata is that peripheral's read data. pSlvErr stays 0.
- R4: A normal-world access to the configuration registers completes at once with pSlvErr=1 and pRdata=0, and changes no setting.
- R5: Config word 0 (word index 0), bit i, is the security bit of peripheral i: 1 means secure-only, 0 means shared by both worlds.
- R6: Config word 1, bits [2i+1:2i], set the mode of master i. mstNonSecure[i] is 1 for mode 00, 0 for mode 01, mstNsIn[i] for mode 10, and 1 for mode 11.
- R7: A secure write to config word 2 with bit 0 = 1 sets a lock that reads back as bit 0 of word 2. While it is set, secure writes to words 0, 1 and 2 complete without error and have no effect. Only reset clears the lock.
- R8: A secure configuration access completes in its first access-phase cycle with pSlvErr=0. Reads return the register value, and word 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pSel | input | NUM_PERIPH | One-hot peripheral select from the bus |
| cfgSel | input | 1 | Select of this block's configuration registers |
| pEnable | input | 1 | Access-phase marker |
| pWrite | input | 1 | 1 = write |
| pNonSecure | input | 1 | Access attribute, 1 = normal world |
| pAddrWord | input | 2 | Configuration word index (address bits above the byte offset) |
| pWdataLow | input | CFG_W | Low bits of write data used by the configuration |
| pRdata | output | DATA_W | Read data returned to the bus |
| pReady | output | 1 | Transfer completion |
| pSlvErr | output | 1 | Error response |
| periSel | output | NUM_PERIPH | Gated select to the peripherals |
| periReady | input | NUM_PERIPH | Ready from each peripheral |
| periRdata | input | NUM_PERIPH*DATA_W | Read data from each peripheral, slot i at [i*DATA_W +: DATA_W] |
| mstNsIn | input | NUM_MST | Attribute bit driven by each master |
| mstNonSecure | output | NUM_MST | Resulting attribute of each master, 1 = normal |

## Verification
The hardest case to reach from the ports is a map change that races with traffic. A random write to the security word can switch a peripheral between shared and secure-only. The very next transfer must then be judged on the new bit while the master attributes move with it. The stimulus mixes random configuration writes from both worlds with random peripheral accesses, random wait states and random master attribute inputs. A bench model updated at each completed write predicts every response. Directed steps then set the lock, try to overwrite each word, and reset in the middle of the run to show that only reset releases the lock.

// File: rtl/psac_pkg.sv
package psac_pkg;

  // Master attribute modes, two bits per master slot
  typedef enum logic [1:0] {
    MST_FIX_NORMAL = 2'b00,
    MST_FIX_SECURE = 2'b01,
    MST_PASS       = 2'b10,
    MST_RESERVED   = 2'b11
  } mst_mode_e;

  // Configuration word indices
  localparam logic [1:0] WORD_PERI = 2'd0;
  localparam logic [1:0] WORD_MST  = 2'd1;
  localparam logic [1:0] WORD_LOCK = 2'd2;

  // Strobes from control to datapath
  typedef struct packed {
    logic wrPeri;
    logic wrMst;
    logic wrLock;
    logic cfgRead;   // return configuration readback
    logic zeroData;  // force read data to zero
  } psac_strobe_t;

endpackage

// File: rtl/psac_ctrl.sv
module psac_ctrl
  import psac_pkg::*;
#(
  parameter int NUM_PERIPH = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_PERIPH-1:0] pSel,
  input  logic                  cfgSel,
  input  logic                  pEnable,
  input  logic                  pWrite,
  input  logic                  pNonSecure,
  input  logic [1:0]            pAddrWord,
  input  logic [NUM_PERIPH-1:0] periMask,
  input  logic                  lockQ,
  input  logic [NUM_PERIPH-1:0] periReady,
  output logic [NUM_PERIPH-1:0] periSel,
  output logic                  pReady,
  output logic                  pSlvErr,
  output psac_strobe_t          strb
);

  logic hitProtected;
  logic blocked;
  logic cfgDenied;
  logic cfgWriteOk;
  logic periAccess;

  // All-or-nothing check on the selected slot
  assign hitProtected = |(pSel & periMask);
  assign blocked      = pNonSecure & hitProtected;
  assign cfgDenied    = cfgSel & pNonSecure;
  assign periAccess   = |pSel;

  // A blocked request never reaches the peripheral
  assign periSel = blocked ? '0 : pSel;

  assign cfgWriteOk = cfgSel & pEnable & pWrite & ~pNonSecure & ~lockQ;

  always_comb begin
    strb          = '0;
    strb.wrPeri   = cfgWriteOk & (pAddrWord == WORD_PERI);
    strb.wrMst    = cfgWriteOk & (pAddrWord == WORD_MST);
    strb.wrLock   = cfgWriteOk & (pAddrWord == WORD_LOCK);
    strb.cfgRead  = cfgSel;
    strb.zeroData = cfgDenied | blocked;
  end

  always_comb begin
    pReady  = 1'b0;
    pSlvErr = 1'b0;
    if (pEnable) begin
      if (cfgSel) begin
        pReady  = 1'b1;
        pSlvErr = pNonSecure;
      end else if (periAccess) begin
        if (blocked) begin
          pReady  = 1'b1;
          pSlvErr = 1'b1;
        end else begin
          pReady  = |(pSel & periReady);
        end
      end
    end
  end

  // Bus contract: at most one peripheral selected
  p_sel_onehot_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(pSel));

  // Normal access to a secure-only slot answers at once with an error and no select
  p_block_resp_r2: assert property (@(posedge clk) disable iff (!rstN)
    (pEnable && pNonSecure && |(pSel & periMask)) |-> (pReady && pSlvErr && periSel == '0));

  // Permitted access passes the select through
  p_pass_sel_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!pNonSecure) |-> (periSel == pSel));

  // Configuration access never waits
  p_cfg_nowait_r8: assert property (@(posedge clk) disable iff (!rstN)
    (cfgSel && pEnable) |-> pReady);

  // Normal-world configuration access produces no write strobe
  p_cfg_nowrite_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cfgSel && pNonSecure) |-> !(strb.wrPeri || strb.wrMst || strb.wrLock));

endmodule

// File: rtl/psac_datapath.sv
module psac_datapath
  import psac_pkg::*;
#(
  parameter int NUM_PERIPH = 8,
  parameter int NUM_MST    = 4,
  parameter int DATA_W     = 32,
  parameter int CFG_W      = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  psac_strobe_t                 strb,
  input  logic [CFG_W-1:0]             pWdataLow,
  input  logic [1:0]                   pAddrWord,
  input  logic [NUM_PERIPH-1:0]        periSel,
  input  logic [NUM_PERIPH*DATA_W-1:0] periRdata,
  input  logic [NUM_MST-1:0]           mstNsIn,
  output logic [NUM_PERIPH-1:0]        periMask,
  output logic                         lockQ,
  output logic [NUM_MST-1:0]           mstNonSecure,
  output logic [DATA_W-1:0]            pRdata
);

  localparam int MST_BITS = 2 * NUM_MST;

  logic [NUM_MST-1:0][1:0] mstMode;
  logic [DATA_W-1:0]       cfgWord;
  logic [DATA_W-1:0]       periWord;

  // Configuration registers: secure-only and fixed-normal out of reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      periMask <= '1;
      mstMode  <= '0;
      lockQ    <= 1'b0;
    end else begin
      if (strb.wrPeri) periMask <= pWdataLow[NUM_PERIPH-1:0];
      if (strb.wrMst)  mstMode  <= pWdataLow[MST_BITS-1:0];
      if (strb.wrLock) lockQ    <= lockQ | pWdataLow[0];
    end
  end

  // Master attribute generation
  for (genvar m = 0; m < NUM_MST; m++) begin : g_mst
    always_comb begin
      unique case (mst_mode_e'(mstMode[m]))
        MST_FIX_SECURE: mstNonSecure[m] = 1'b0;
        MST_PASS:       mstNonSecure[m] = mstNsIn[m];
        default:        mstNonSecure[m] = 1'b1;
      endcase
    end
  end

  // Configuration readback
  always_comb begin
    cfgWord = '0;
    case (pAddrWord)
      WORD_PERI: cfgWord[NUM_PERIPH-1:0] = periMask;
      WORD_MST:  cfgWord[MST_BITS-1:0]   = mstMode;
      WORD_LOCK: cfgWord[0]              = lockQ;
      default:   cfgWord                 = '0;
    endcase
  end

  // Peripheral read data selected by the gated select
  always_comb begin
    periWord = '0;
    for (int i = 0; i < NUM_PERIPH; i++) begin
      if (periSel[i]) periWord = periRdata[i*DATA_W +: DATA_W];
    end
  end

  assign pRdata = strb.zeroData ? '0 : (strb.cfgRead ? cfgWord : periWord);

  // Lock is sticky until reset
  p_lock_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    lockQ |=> lockQ);

  // Locked settings do not move
  p_frozen_r7: assert property (@(posedge clk) disable iff (!rstN)
    lockQ |=> ($stable(periMask) && $stable(mstMode)));

  // Fixed-secure master never reports normal
  p_fix_secure_r6: assert property (@(posedge clk) disable iff (!rstN)
    (mstMode[0] == 2'b01) |-> !mstNonSecure[0]);

endmodule

// File: rtl/psac_top.sv
module psac_top
  import psac_pkg::*;
#(
  parameter int NUM_PERIPH = 8,
  parameter int NUM_MST    = 4,
  parameter int DATA_W     = 32,
  localparam int CFG_W     = (NUM_PERIPH > 2*NUM_MST) ? NUM_PERIPH : 2*NUM_MST
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [NUM_PERIPH-1:0]        pSel,
  input  logic                         cfgSel,
  input  logic                         pEnable,
  input  logic                         pWrite,
  input  logic                         pNonSecure,
  input  logic [1:0]                   pAddrWord,
  input  logic [CFG_W-1:0]             pWdataLow,
  output logic [DATA_W-1:0]            pRdata,
  output logic                         pReady,
  output logic                         pSlvErr,
  output logic [NUM_PERIPH-1:0]        periSel,
  input  logic [NUM_PERIPH-1:0]        periReady,
  input  logic [NUM_PERIPH*DATA_W-1:0] periRdata,
  input  logic [NUM_MST-1:0]           mstNsIn,
  output logic [NUM_MST-1:0]           mstNonSecure
);

  psac_strobe_t          strb;
  logic [NUM_PERIPH-1:0] periMask;
  logic                  lockQ;

  psac_ctrl #(.NUM_PERIPH(NUM_PERIPH)) u_ctrl (
    .clk(clk), .rstN(rstN), .pSel(pSel), .cfgSel(cfgSel), .pEnable(pEnable),
    .pWrite(pWrite), .pNonSecure(pNonSecure), .pAddrWord(pAddrWord),
    .periMask(periMask), .lockQ(lockQ), .periReady(periReady),
    .periSel(periSel), .pReady(pReady), .pSlvErr(pSlvErr), .strb(strb)
  );

  psac_datapath #(
    .NUM_PERIPH(NUM_PERIPH), .NUM_MST(NUM_MST), .DATA_W(DATA_W), .CFG_W(CFG_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .pWdataLow(pWdataLow),
    .pAddrWord(pAddrWord), .periSel(periSel), .periRdata(periRdata),
    .mstNsIn(mstNsIn), .periMask(periMask), .lockQ(lockQ),
    .mstNonSecure(mstNonSecure), .pRdata(pRdata)
  );

endmodule

// File: tb/psac_top_test.sv
module psac_top_test;

  localparam int NP = 8;
  localparam int NM = 4;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NP-1:0] pSel = '0;
  logic          cfgSel = 1'b0;
  logic          pEnable = 1'b0;
  logic          pWrite = 1'b0;
  logic          pNonSecure = 1'b0;
  logic [1:0]    pAddrWord = '0;
  logic [7:0]    pWdataLow = '0;
  logic [DW-1:0] pRdata;
  logic          pReady;
  logic          pSlvErr;
  logic [NP-1:0] periSel;
  logic [NP-1:0] readyVec = '1;
  logic [NP*DW-1:0] periRdata;
  logic [NM-1:0] mstNsIn = '0;
  logic [NM-1:0] mstNonSecure;

  int checks = 0;
  int errors = 0;

  // Bench model of the configuration
  logic [7:0] modelPeri;
  logic [7:0] modelMst;
  logic       modelLock;

  always #10 clk = ~clk;   // 50 MHz

  for (genvar i = 0; i < NP; i++) begin : g_pd
    assign periRdata[i*DW +: DW] = 32'hC0DE_0000 + 32'(i * 17);
  end

  psac_top uut (
    .clk(clk), .rstN(rstN), .pSel(pSel), .cfgSel(cfgSel), .pEnable(pEnable),
    .pWrite(pWrite), .pNonSecure(pNonSecure), .pAddrWord(pAddrWord),
    .pWdataLow(pWdataLow), .pRdata(pRdata), .pReady(pReady), .pSlvErr(pSlvErr),
    .periSel(periSel), .periReady(readyVec), .periRdata(periRdata),
    .mstNsIn(mstNsIn), .mstNonSecure(mstNonSecure)
  );

  function automatic logic [NM-1:0] expMst(logic [7:0] modes, logic [NM-1:0] nsIn);
    logic [NM-1:0] r;
    for (int m = 0; m < NM; m++) begin
      case (modes[2*m +: 2])
        2'b01:   r[m] = 1'b0;
        2'b10:   r[m] = nsIn[m];
        default: r[m] = 1'b1;
      endcase
    end
    return r;
  endfunction

  function automatic logic [31:0] expCfg(logic [1:0] w);
    case (w)
      2'd0:    return {24'h0, modelPeri};
      2'd1:    return {24'h0, modelMst};
      2'd2:    return {31'h0, modelLock};
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic resetModel();
    modelPeri = 8'hFF;
    modelMst  = 8'h00;
    modelLock = 1'b0;
  endtask

  // One bus transfer with full checking against the model
  task automatic run(input bit isCfg, input int slot, input bit wr, input bit ns,
                     input logic [1:0] word, input logic [7:0] wd, input int hold);
    logic [NP-1:0] selS, selA, expSel;
    logic [31:0]   rd, expRd;
    logic          err;
    logic [NM-1:0] mstOut, nsIn;
    int            waits;
    bit            blockedE;
    string         tag;

    blockedE = !isCfg && ns && modelPeri[slot];
    if (isCfg) tag = ns ? "R4" : (modelLock ? "R7" : "R8");
    else if (blockedE) tag = "R2";
    else tag = (ns && !modelPeri[slot]) ? "R5" : "R3";

    @(negedge clk);
    nsIn       = 4'($urandom);
    mstNsIn    = nsIn;
    cfgSel     = isCfg;
    pSel       = isCfg ? '0 : (NP'(1) << slot);
    pWrite     = wr;
    pNonSecure = ns;
    pAddrWord  = word;
    pWdataLow  = wd;
    pEnable    = 1'b0;
    #2;
    selS   = periSel;
    mstOut = mstNonSecure;
    @(negedge clk);
    pEnable = 1'b1;
    if (!isCfg && !blockedE && hold > 0) readyVec[slot] = 1'b0;
    waits = 0;
    #2;
    while (!pReady && waits < 50) begin
      waits++;
      if (waits >= hold) readyVec = '1;
      @(negedge clk);
      #2;
    end
    rd   = pRdata;
    err  = pSlvErr;
    selA = periSel;
    @(posedge clk);
    #1;
    pSel = '0; cfgSel = 1'b0; pEnable = 1'b0; readyVec = '1;

    expSel = (isCfg || blockedE) ? '0 : (NP'(1) << slot);
    chk({tag, " select setup"},  32'(selS), 32'(expSel));
    chk({tag, " select access"}, 32'(selA), 32'(expSel));
    chk({tag, " error"}, 32'(err), 32'(isCfg ? ns : blockedE));
    chk({tag, " wait cycles"}, 32'(waits), 32'((isCfg || blockedE) ? 0 : hold));
    chk("R6 master attribute", 32'(mstOut), 32'(expMst(modelMst, nsIn)));
    if (!wr) begin
      if (isCfg) expRd = ns ? 32'h0 : expCfg(word);
      else       expRd = blockedE ? 32'h0 : 32'hC0DE_0000 + 32'(slot * 17);
      chk({tag, " read data"}, rd, expRd);
    end

    if (isCfg && wr && !ns && !modelLock) begin
      case (word)
        2'd0: modelPeri = wd;
        2'd1: modelMst  = wd;
        2'd2: modelLock = modelLock | wd[0];
        default: ;
      endcase
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    resetModel();
  endtask

  // Watchdog
  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    resetModel();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #2;
    // R1: idle outputs and attributes after reset
    chk("R1 master attributes", 32'(mstNonSecure), 32'hF);
    chk("R1 idle ready", 32'(pReady), 32'h0);
    chk("R1 idle select", 32'(periSel), 32'h0);
    run(1, 0, 0, 0, 2'd0, 8'h00, 0);  // R1 word 0 all ones
    run(1, 0, 0, 0, 2'd1, 8'h00, 0);  // R1 modes zero
    run(1, 0, 0, 0, 2'd2, 8'h00, 0);  // R1 lock clear

    run(0, 2, 0, 1, 2'd0, 8'h00, 0);  // R2 blocked read
    run(0, 6, 1, 1, 2'd0, 8'h00, 0);  // R2 blocked write
    run(0, 2, 0, 0, 2'd0, 8'h00, 2);  // R3 secure read with waits
    run(1, 0, 1, 1, 2'd0, 8'h00, 0);  // R4 normal write to config
    run(1, 0, 0, 0, 2'd0, 8'h00, 0);  // R4 unchanged
    run(1, 0, 0, 1, 2'd1, 8'h00, 0);  // R4 normal read gives zero
    run(1, 0, 1, 0, 2'd0, 8'h0F, 0);  // R5 low half secure-only
    run(0, 5, 0, 1, 2'd0, 8'h00, 1);  // R5 shared slot from normal world
    run(0, 1, 0, 1, 2'd0, 8'h00, 0);  // R5 protected slot blocked
    run(1, 0, 1, 0, 2'd1, 8'hE4, 0);  // R6 modes 11,10,01,00
    for (int k = 0; k < 4; k++) run(0, 7, 0, 0, 2'd0, 8'h00, 0);  // R6 attribute sweep
    run(1, 0, 0, 0, 2'd3, 8'h00, 0);  // R8 word 3 reads zero

    // Random mix of configuration writes and peripheral traffic
    for (int n = 0; n < 400; n++) begin
      int  sel = int'($urandom_range(0, 9));
      bit  ns  = 1'($urandom);
      if (sel < 2)
        run(1, 0, 1'($urandom), ns, 2'($urandom_range(0, 1)), 8'($urandom), 0);
      else if (sel == 2)
        run(1, 0, 0, ns, 2'($urandom_range(0, 3)), 8'h00, 0);
      else
        run(0, int'($urandom_range(0, NP-1)), 1'($urandom), ns, 2'd0, 8'h00,
            int'($urandom_range(0, 3)));
    end

    // R7: lock, then attempt every word
    run(1, 0, 1, 0, 2'd2, 8'h00, 0);  // writing 0 does not lock
    run(1, 0, 0, 0, 2'd2, 8'h00, 0);
    run(1, 0, 1, 0, 2'd0, 8'h3C, 0);
    run(1, 0, 1, 0, 2'd2, 8'h01, 0);  // lock
    run(1, 0, 1, 0, 2'd0, 8'hA5, 0);  // R7 ignored
    run(1, 0, 1, 0, 2'd1, 8'h55, 0);  // R7 ignored
    run(1, 0, 1, 0, 2'd2, 8'h00, 0);  // R7 cannot unlock
    run(1, 0, 0, 0, 2'd0, 8'h00, 0);
    run(1, 0, 0, 0, 2'd1, 8'h00, 0);
    run(1, 0, 0, 0, 2'd2, 8'h00, 0);
    run(0, 2, 0, 1, 2'd0, 8'h00, 0);  // R7 frozen map still enforced
    run(0, 0, 0, 1, 2'd0, 8'h00, 0);

    // R7: only reset releases the lock
    doReset();
    run(1, 0, 0, 0, 2'd2, 8'h00, 0);
    run(1, 0, 0, 0, 2'd0, 8'h00, 0);
    run(1, 0, 1, 0, 2'd0, 8'h81, 0);
    run(1, 0, 0, 0, 2'd0, 8'h00, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule